// File: doc/BRIEF.md
# Averaging ADC Channel Sequencer

This block decides what a single shared analog-to-digital converter measures next. It walks a programmed list of up to eight primary entries, where each entry names a channel and an averaging exponent. For each entry it requests 2^e conversions, sums the raw codes, and reports the sum shifted right by e as one averaged result. When the last entry is done, the list starts again from entry 0, and this continues until a stop request.

An auxiliary slot follows each primary entry. Two sample-and-hold inputs become pending when their trigger pulses. The slot after a primary entry goes to a pending sample-and-hold channel, and that channel completes its whole averaging run inside the slot. If nothing is pending, the slot is skipped. The slot after the last entry of the list always goes to the internal temperature channel, which takes exactly one sample per pass. The temperature average is built up across passes.

The converter is abstract. The block holds a request with a channel number, and the converter answers with a done pulse and one raw code. Every averaged result leaves the block as a one-cycle strobe with its channel ID. A pass marker pulses together with the result of the last list entry.

Top module: `avg_seq_top`

## Requirements
- R1: Primary entries run in order from index 0 up to `last_idx_i`. After the entry at `last_idx_i`, the sequence continues at entry 0 and keeps repeating while running.
- R2: An entry with exponent e takes 2^e conversions, and its result is the sum of the codes shifted right by e. Exponents 0 to 4 give 1, 2, 4, 8 or 16 samples. Values 5 to 7 are treated as 4.
- R3: After a primary entry that is not the last one, the auxiliary slot goes to S/H0 if S/H0 is pending. Otherwise it goes to S/H1 if S/H1 is pending. If neither is pending, the slot is skipped and the next primary entry starts.
- R4: A one-cycle pulse on `sh_trig_i[n]` makes S/H channel n pending, and it stays pending until its slot is granted. In that one slot the channel takes all 2^e samples set by `sh_exp_i[3n+:3]` and gives one result, with ID `SH0_ID` (16) for channel 0 or `SH1_ID` (17) for channel 1.
- R5: The auxiliary slot after the last entry is always the temperature channel (ID `TEMP_ID` = 18). It takes one sample per pass. A temperature result, the average of the last 2^`temp_exp_i` samples, is reported once every 2^`temp_exp_i` passes. A start clears any partial temperature sum.
- R6: `seq_end_o` pulses for exactly one cycle, in the same cycle as the result of the entry at `last_idx_i`.
- R7: `conv_req_o` stays high with `conv_ch_o` stable until `conv_done_i` is seen. `conv_code_i` is taken in that same cycle. After each done, `conv_req_o` is low for at least one cycle.
- R8: `res_valid_o` is a one-cycle strobe that comes one clock after the final done of a slot, with `res_ch_o` and `res_data_o` valid during that cycle.
- R9: After `stop_i`, the slot in progress completes and reports its result. No further request is made until the next `start_i`. A pending trigger alone never starts a request.
- R10: While `rst_ni` is low, and in the idle state after it, `conv_req_o`, `res_valid_o` and `seq_end_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start the list at entry 0 (only acted on when idle) |
| stop_i | input | 1 | Halt after the current slot |
| last_idx_i | input | 3 | Index of the last primary entry |
| entry_ch_i | input | 40 | Channel number per entry, 5 bits each, entry i at [5i+:5] |
| entry_exp_i | input | 24 | Averaging exponent per entry, 3 bits each, entry i at [3i+:3] |
| sh_trig_i | input | 2 | Trigger pulses for S/H0 (bit 0) and S/H1 (bit 1) |
| sh_exp_i | input | 6 | Averaging exponents for S/H0 [2:0] and S/H1 [5:3] |
| temp_exp_i | input | 3 | Temperature averaging exponent (number of passes) |
| conv_req_o | output | 1 | Conversion request |
| conv_ch_o | output | 5 | Channel to convert |
| conv_done_i | input | 1 | Conversion complete, code valid |
| conv_code_i | input | 12 | Raw conversion code |
| res_valid_o | output | 1 | Averaged result strobe |
| res_ch_o | output | 5 | Channel ID of the result |
| res_data_o | output | 12 | Averaged result |
| seq_end_o | output | 1 | End-of-pass pulse |

## Verification
The embedded properties check the cycle-level rules on every cycle:
- the channel stays stable during a request, and the request drops after each done;
- every result strobe follows a done;
- the pass marker is a single cycle and coincides with a result;
- a sample counter never reaches the slot's limit;
- a pending flag never clears unless its slot is granted.

The following can only be shown by the bench's scenarios, which compare the full result stream against expected values:
- the order of slots;
- the priority of S/H0 over S/H1;
- skipping of empty auxiliary slots;
- temperature averaging across passes;
- clamping of the exponent;
- the exact point at which a stop takes effect.

// File: rtl/avg_seq_pkg.sv
package avg_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    K_PRIM = 2'd0,
    K_SH0  = 2'd1,
    K_SH1  = 2'd2,
    K_TEMP = 2'd3
  } slot_kind_e;

  // Exponent limited to 16 samples
  function automatic logic [2:0] clamp_exp(input logic [2:0] e);
    return (e > 3'd4) ? 3'd4 : e;
  endfunction

endpackage

// File: rtl/avg_seq_pend.sv
module avg_seq_pend #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] pend_q, pend_d;

  for (genvar g = 0; g < N; g++) begin : g_pend
    always_comb begin
      pend_d[g] = pend_q[g];
      if (clr_i[g])  pend_d[g] = 1'b0;
      if (trig_i[g]) pend_d[g] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else         pend_q[g] <= pend_d[g];
    end

    // R4: a pending channel stays pending until its slot is granted
    p_pend_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q[g] && !clr_i[g] |=> pend_q[g]);
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/avg_seq_pick.sv
module avg_seq_pick
  import avg_seq_pkg::*;
(
  input  logic       prim_i,
  input  logic       last_i,
  input  logic [1:0] pend_i,
  output slot_kind_e kind_o
);

  always_comb begin
    if (!prim_i)        kind_o = K_PRIM;
    else if (last_i)    kind_o = K_TEMP;
    else if (pend_i[0]) kind_o = K_SH0;
    else if (pend_i[1]) kind_o = K_SH1;
    else                kind_o = K_PRIM;
  end

endmodule

// File: rtl/avg_seq_temp.sv
module avg_seq_temp #(
  parameter int CODE_W = 12,
  parameter int ACC_W  = CODE_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [2:0]        exp_i,
  output logic              done_o,
  output logic [CODE_W-1:0] avg_o
);

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic [4:0]       cnt_q, cnt_d, limit;

  assign limit  = 5'd1 << exp_i;
  assign sum    = acc_q + {{(ACC_W-CODE_W){1'b0}}, code_i};
  assign done_o = add_i && ((cnt_q + 5'd1) == limit);
  assign avg_o  = CODE_W'(sum >> exp_i);

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clear_i || done_o) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (add_i) begin
      acc_d = sum;
      cnt_d = cnt_q + 5'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R5: partial pass count stays below the programmed window
  p_temp_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < 5'd16);

endmodule

// File: rtl/avg_seq_top.sv
module avg_seq_top
  import avg_seq_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int CODE_W      = 12,
  parameter int CH_W        = 5,
  parameter int SH0_ID      = 16,
  parameter int SH1_ID      = 17,
  parameter int TEMP_ID     = 18,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int EXP_W      = 3,
  localparam int ACC_W      = CODE_W + 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         stop_i,
  input  logic [IDX_W-1:0]             last_idx_i,
  input  logic [NUM_ENTRIES*CH_W-1:0]  entry_ch_i,
  input  logic [NUM_ENTRIES*EXP_W-1:0] entry_exp_i,
  input  logic [1:0]                   sh_trig_i,
  input  logic [2*EXP_W-1:0]           sh_exp_i,
  input  logic [EXP_W-1:0]             temp_exp_i,
  output logic                         conv_req_o,
  output logic [CH_W-1:0]              conv_ch_o,
  input  logic                         conv_done_i,
  input  logic [CODE_W-1:0]            conv_code_i,
  output logic                         res_valid_o,
  output logic [CH_W-1:0]              res_ch_o,
  output logic [CODE_W-1:0]            res_data_o,
  output logic                         seq_end_o
);

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  seq_state_e        state_q, state_d;
  slot_kind_e        kind_q, kind_d, pick_kind;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [4:0]        cnt_q, cnt_d, samp_cnt;
  logic [ACC_W-1:0]  acc_q, acc_d, acc_sum, acc_shift;
  logic              stop_q, stop_d;
  logic [CH_W-1:0]   ch_q, ch_d, cur_ch;
  logic [EXP_W-1:0]  cur_exp;
  logic              rv_q, rv_d, end_q, end_d;
  logic [CH_W-1:0]   rch_q, rch_d;
  logic [CODE_W-1:0] rdat_q, rdat_d;
  logic              take, slot_done, is_last, leaving;
  logic [1:0]        sh_pend, sh_clr;
  logic              temp_clear, temp_add, temp_done;
  logic [CODE_W-1:0] temp_avg;

  avg_seq_pend #(.N(2)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (sh_trig_i),
    .clr_i  (sh_clr),
    .pend_o (sh_pend)
  );

  avg_seq_pick u_pick (
    .prim_i (kind_q == K_PRIM),
    .last_i (is_last),
    .pend_i (sh_pend),
    .kind_o (pick_kind)
  );

  avg_seq_temp #(.CODE_W(CODE_W), .ACC_W(ACC_W)) u_temp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (temp_clear),
    .add_i   (temp_add),
    .code_i  (conv_code_i),
    .exp_i   (clamp_exp(temp_exp_i)),
    .done_o  (temp_done),
    .avg_o   (temp_avg)
  );

  // Channel and exponent of the current slot
  always_comb begin
    unique case (kind_q)
      K_SH0:   begin cur_ch = CH_W'(SH0_ID);  cur_exp = clamp_exp(sh_exp_i[0 +: EXP_W]); end
      K_SH1:   begin cur_ch = CH_W'(SH1_ID);  cur_exp = clamp_exp(sh_exp_i[EXP_W +: EXP_W]); end
      K_TEMP:  begin cur_ch = CH_W'(TEMP_ID); cur_exp = '0; end
      default: begin
        cur_ch  = entry_ch_i[idx_q*CH_W +: CH_W];
        cur_exp = clamp_exp(entry_exp_i[idx_q*EXP_W +: EXP_W]);
      end
    endcase
  end

  assign samp_cnt  = 5'd1 << cur_exp;
  assign take      = (state_q == S_WAIT) && conv_done_i;
  assign acc_sum   = acc_q + {{(ACC_W-CODE_W){1'b0}}, conv_code_i};
  assign acc_shift = acc_sum >> cur_exp;
  assign slot_done = take && ((cnt_q + 5'd1) == samp_cnt);
  assign is_last   = (idx_q == last_idx_i);
  assign leaving   = stop_q || stop_i;
  assign temp_add  = slot_done && (kind_q == K_TEMP);

  always_comb begin
    state_d    = state_q;
    kind_d     = kind_q;
    idx_d      = idx_q;
    cnt_d      = cnt_q;
    acc_d      = acc_q;
    ch_d       = ch_q;
    rch_d      = rch_q;
    rdat_d     = rdat_q;
    rv_d       = 1'b0;
    end_d      = 1'b0;
    sh_clr     = 2'b00;
    temp_clear = 1'b0;
    stop_d     = stop_q || ((state_q != S_IDLE) && stop_i);
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d    = S_ISSUE;
          kind_d     = K_PRIM;
          idx_d      = '0;
          cnt_d      = '0;
          acc_d      = '0;
          stop_d     = 1'b0;
          temp_clear = 1'b1;
        end
      end
      S_ISSUE: begin
        ch_d    = cur_ch;
        state_d = S_WAIT;
      end
      S_WAIT: begin
        if (take) begin
          state_d = S_ISSUE;
          acc_d   = acc_sum;
          cnt_d   = cnt_q + 5'd1;
        end
        if (slot_done) begin
          acc_d  = '0;
          cnt_d  = '0;
          rch_d  = ch_q;
          rdat_d = CODE_W'(acc_shift);
          rv_d   = 1'b1;
          kind_d = K_PRIM;
          if (kind_q == K_PRIM) begin
            end_d  = is_last;
            idx_d  = is_last ? '0 : idx_q + IDX_ONE;
            kind_d = pick_kind;
            if (!leaving) begin
              sh_clr[0] = (pick_kind == K_SH0);
              sh_clr[1] = (pick_kind == K_SH1);
            end
          end else if (kind_q == K_TEMP) begin
            rv_d   = temp_done;
            rdat_d = temp_avg;
          end
          if (leaving) begin
            state_d = S_IDLE;
            stop_d  = 1'b0;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_PRIM;
      idx_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      stop_q  <= 1'b0;
      ch_q    <= '0;
      rv_q    <= 1'b0;
      end_q   <= 1'b0;
      rch_q   <= '0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      stop_q  <= stop_d;
      ch_q    <= ch_d;
      rv_q    <= rv_d;
      end_q   <= end_d;
      rch_q   <= rch_d;
      rdat_q  <= rdat_d;
    end
  end

  assign conv_req_o  = (state_q == S_WAIT);
  assign conv_ch_o   = ch_q;
  assign res_valid_o = rv_q;
  assign res_ch_o    = rch_q;
  assign res_data_o  = rdat_q;
  assign seq_end_o   = end_q;

  // R7: channel held while a request is open
  p_ch_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o && !conv_done_i |=> conv_req_o && $stable(conv_ch_o));
  // R7: request drops after each done
  p_req_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o && conv_done_i |=> !conv_req_o);
  // R8: every result follows a done one clock earlier
  p_res_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(conv_done_i));
  // R6: pass marker coincides with a result and lasts one cycle
  p_end_with_res_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_end_o |-> res_valid_o);
  p_end_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_end_o |=> !seq_end_o);
  // R2: sample counter never reaches the slot limit
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) |-> (cnt_q < samp_cnt));

endmodule

// File: tb/avg_seq_top_tb_top.sv
module avg_seq_top_tb_top;

  localparam int N   = 8;
  localparam int CW  = 12;
  localparam int CHW = 5;
  localparam int EW  = 3;
  localparam int NTBL = 12;

  // {channel, data, end flag}
  localparam int EXP_TBL [NTBL][3] = '{
    '{1,  102,  0}, '{16, 1602, 0}, '{3,  300,  0}, '{17, 1702, 0},
    '{7,  702,  0}, '{2,  202,  1}, '{1,  102,  0}, '{3,  304,  0},
    '{7,  702,  0}, '{2,  202,  1}, '{18, 1802, 0}, '{1,  102,  0}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, start, stop, conv_req, conv_done, res_valid, seq_end;
  logic [2:0]        last_idx, temp_exp;
  logic [N*CHW-1:0]  entry_ch;
  logic [N*EW-1:0]   entry_exp;
  logic [1:0]        sh_trig;
  logic [2*EW-1:0]   sh_exp;
  logic [CHW-1:0]    conv_ch, res_ch;
  logic [CW-1:0]     conv_code, res_data;

  avg_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .last_idx_i(last_idx), .entry_ch_i(entry_ch), .entry_exp_i(entry_exp),
    .sh_trig_i(sh_trig), .sh_exp_i(sh_exp), .temp_exp_i(temp_exp),
    .conv_req_o(conv_req), .conv_ch_o(conv_ch), .conv_done_i(conv_done),
    .conv_code_i(conv_code), .res_valid_o(res_valid), .res_ch_o(res_ch),
    .res_data_o(res_data), .seq_end_o(seq_end)
  );

  int n_chk = 0;
  int n_fail = 0;
  int k_cnt [32];
  int wcnt = 0;
  int n_res = 0;
  int n_end = 0;
  int r_ch [32];
  int r_dat [32];
  int r_end [32];

  // Converter model: code = ch*100 + 4 on every odd sample of that channel
  always @(negedge clk) begin
    if (conv_done) conv_done <= 1'b0;
    else if (conv_req) begin
      if (wcnt == 2) begin
        conv_done <= 1'b1;
        conv_code <= CW'(int'(conv_ch) * 100 + (k_cnt[conv_ch] % 2) * 4);
        k_cnt[conv_ch] = k_cnt[conv_ch] + 1;
        wcnt = 0;
      end else wcnt = wcnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && res_valid && n_res < 32) begin
      r_ch[n_res]  = int'(res_ch);
      r_dat[n_res] = int'(res_data);
      r_end[n_res] = int'(seq_end);
      n_res = n_res + 1;
    end
    if (rst_n && seq_end) n_end = n_end + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wait_res(input int target);
    for (int i = 0; i < 20000 && n_res < target; i++) tick(1);
  endtask

  task automatic pulse_start();
    start = 1'b1; tick(1); start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1; tick(1); stop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) k_cnt[i] = 0;
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; sh_trig = 2'b00;
    conv_done = 1'b0; conv_code = '0;
    last_idx = 3'd3; temp_exp = 3'd1;
    entry_ch = '0; entry_exp = '0;
    entry_ch[0*CHW +: CHW] = 5'd1; entry_exp[0*EW +: EW] = 3'd2;
    entry_ch[1*CHW +: CHW] = 5'd3; entry_exp[1*EW +: EW] = 3'd0;
    entry_ch[2*CHW +: CHW] = 5'd7; entry_exp[2*EW +: EW] = 3'd3;
    entry_ch[3*CHW +: CHW] = 5'd2; entry_exp[3*EW +: EW] = 3'd1;
    sh_exp = {3'd2, 3'd1};
    tick(3);
    // R10: reset state
    chk(!conv_req && !res_valid && !seq_end, "R10 reset outputs", int'(conv_req), 0);
    rst_n = 1'b1;
    tick(2);
    // R4 triggers while idle; R9 no request from a trigger alone
    sh_trig = 2'b11; tick(1); sh_trig = 2'b00;
    tick(10);
    chk(!conv_req, "R9 idle with pending trigger", int'(conv_req), 0);

    pulse_start();
    wait_res(11);
    pulse_stop();
    tick(400);
    chk(n_res == 12, "R9 one slot completes after stop", n_res, 12);
    chk(!conv_req, "R9 no request after stop", int'(conv_req), 0);

    for (int i = 0; i < NTBL; i++) begin
      chk(r_ch[i] == EXP_TBL[i][0], $sformatf("R1 R3 R4 R5 order #%0d", i), r_ch[i], EXP_TBL[i][0]);
      chk(r_dat[i] == EXP_TBL[i][1], $sformatf("R2 R8 value #%0d", i), r_dat[i], EXP_TBL[i][1]);
      chk(r_end[i] == EXP_TBL[i][2], $sformatf("R6 end flag #%0d", i), r_end[i], EXP_TBL[i][2]);
    end
    chk(n_end == 2, "R6 pass marker count", n_end, 2);
    chk(k_cnt[16] == 2, "R4 S/H0 samples in one slot", k_cnt[16], 2);
    chk(k_cnt[17] == 4, "R4 S/H1 samples in one slot", k_cnt[17], 4);
    chk(k_cnt[18] == 2, "R5 one temperature sample per pass", k_cnt[18], 2);
    chk(k_cnt[7] == 16, "R2 eight samples per pass", k_cnt[7], 16);

    // Single entry, exponent 7 clamps to 16 samples; temperature every pass
    last_idx = 3'd0;
    entry_ch[0*CHW +: CHW] = 5'd5; entry_exp[0*EW +: EW] = 3'd7;
    temp_exp = 3'd0;
    pulse_start();
    wait_res(14);
    pulse_stop();
    tick(400);
    chk(n_res == 15, "R9 stop in single-entry list", n_res, 15);
    chk(r_ch[12] == 5 && r_dat[12] == 502, "R2 clamped average", r_dat[12], 502);
    chk(r_end[12] == 1, "R6 end on single entry", r_end[12], 1);
    chk(r_ch[13] == 18 && r_dat[13] == 1800, "R5 temperature after restart", r_dat[13], 1800);
    chk(r_ch[14] == 5 && r_dat[14] == 502, "R1 wrap to entry 0", r_dat[14], 502);
    chk(k_cnt[5] == 32, "R2 clamp to 16 samples", k_cnt[5], 32);

    // R10: reset in the middle of a run
    pulse_start();
    tick(20);
    rst_n = 1'b0;
    tick(1);
    chk(!conv_req && !res_valid && !seq_end, "R10 reset mid-run", int'(conv_req), 0);
    rst_n = 1'b1;
    tick(50);
    chk(!conv_req, "R10 idle after reset", int'(conv_req), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule